// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is a registered arithmetic slice for signal-processing datapaths. Two 25-bit signed operands, A and D, are combined in a pre-adder that can add or subtract. The sum is multiplied by an 18-bit signed operand B. The 48-bit product M then meets a second operand Z in a post-adder. Z is picked at run time from zero, a 48-bit cascade input, the slice's own registered result, or a 48-bit C input. The post-adder applies one of four sign forms. The full 48-bit result is registered as P. P drives a cascade output, so a following slice can add it through its own cascade selection.

A 5-bit mode word arrives with the operands and travels down the pipeline with them, so the operation can change on every clock. The input, multiplier and output register groups each have their own clock enable. With the pre-adder built in, a result appears four clocks after its operands; with the pre-adder left out by parameter, it appears after three. A restart/accumulate pattern works as follows: select Z=C on the first term, then select Z=P on the terms after it, and the slice sums one product per clock. A parameter drops low-order bits from the exposed result.

Top module: `premac_slice`

## Requirements
- R1: The active-low reset `rst_n` clears every pipeline register as soon as it is asserted, so `p_o` and `casc_o` read zero. Its release takes effect through a two-flop synchronizer.
- R2: With `USE_PREADD=1` a result is visible on `p_o` after the 4th rising edge following the edge that samples its operands. With `USE_PREADD=0` it is visible after the 3rd.
- R3: With the pre-adder built in, mode bit 4 = 0 makes the multiplier operand A+D and bit 4 = 1 makes it A-D. With `USE_PREADD=0`, the product is A*B and D and mode bit 4 have no effect.
- R4: Mode bits [3:2] select Z: 00 gives zero, 01 gives `casc_i` (sampled on the edge that updates P), 10 gives the current P, and 11 gives C.
- R5: Mode bits [1:0] select the post-adder form: 00 gives Z+M, 01 gives M-Z, 10 gives -(Z+M+1), and 11 gives Z-M.
- R6: A term with Z=C followed by terms with Z=P on consecutive clocks leaves P equal to C plus the sum of all the products.
- R7: All arithmetic wraps modulo 2^48 and does not saturate.
- R8: `casc_o` always carries the full 48-bit P.
- R9: `p_o` equals bits [47:DROP_LSB] of P.
- R10: While `ce_a` is low, the A, D, pre-adder and input/pre-adder mode registers hold their values, so a vector presented then is not taken in.
- R11: While `ce_b` is low, the B registers hold their values.
- R12: While `ce_c` is low, the C registers in front of the multiplier stage hold their values.
- R13: While `ce_m` is low, the product and the C and mode values aligned with it hold. The next P update therefore applies the same product again.
- R14: While `ce_p` is low, P holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_a | input | 1 | Enable for A, D, pre-adder and front mode registers |
| ce_b | input | 1 | Enable for B registers |
| ce_c | input | 1 | Enable for front C registers |
| ce_m | input | 1 | Enable for multiplier stage registers |
| ce_p | input | 1 | Enable for the P register |
| mode_i | input | 5 | [4] pre-adder subtract, [3:2] Z source, [1:0] post-adder form |
| a_i | input | 25 | Signed A operand |
| d_i | input | 25 | Signed D operand |
| b_i | input | 18 | Signed B operand |
| c_i | input | 48 | C operand |
| casc_i | input | 48 | Cascade input from a preceding slice |
| p_o | output | 48-DROP_LSB | Result P with DROP_LSB low bits removed |
| casc_o | output | 48 | Full P for a following slice |

## Verification
The accumulate feedback (Z=P) and a multiplier-stage stall can act on the same P update. When `ce_m` drops for one edge just after an accumulate term reaches the multiplier register, P must take that product twice. The result is judged as the old P plus twice the product, with one application seen in between. A stall of the P register on the very edge a restart term arrives is also provoked; that term must be lost while P keeps its old value.

// File: rtl/premac_pkg.sv
package premac_pkg;

  typedef enum logic [1:0] {
    ZS_ZERO = 2'b00,
    ZS_CASC = 2'b01,
    ZS_PREG = 2'b10,
    ZS_CIN  = 2'b11
  } zsel_e;

  typedef enum logic [1:0] {
    ALU_ZPM = 2'b00,
    ALU_MMZ = 2'b01,
    ALU_INV = 2'b10,
    ALU_ZMM = 2'b11
  } aluop_e;

  typedef struct packed {
    logic   pre_sub;
    zsel_e  zsel;
    aluop_e op;
  } mode_t;

endpackage

// File: rtl/premac_rst_sync.sv
module premac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/premac_front.sv
module premac_front
  import premac_pkg::*;
#(
  parameter int A_W        = 25,
  parameter int B_W        = 18,
  parameter int P_W        = 48,
  parameter int USE_PREADD = 1,
  localparam int MA_W      = A_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_a,
  input  logic                   ce_b,
  input  logic                   ce_c,
  input  logic signed [A_W-1:0]  a_i,
  input  logic signed [A_W-1:0]  d_i,
  input  logic signed [B_W-1:0]  b_i,
  input  logic [P_W-1:0]         c_i,
  input  mode_t                  mode_i,
  output logic signed [MA_W-1:0] mul_a_o,
  output logic signed [B_W-1:0]  mul_b_o,
  output logic [P_W-1:0]         c_o,
  output mode_t                  mode_o
);

  // input register stage
  logic signed [A_W-1:0] a1_q, a1_d;
  logic signed [A_W-1:0] d1_q, d1_d;
  logic signed [B_W-1:0] b1_q, b1_d;
  logic [P_W-1:0]        c1_q, c1_d;
  mode_t                 md1_q, md1_d;

  always_comb begin
    a1_d  = a1_q;
    d1_d  = d1_q;
    md1_d = md1_q;
    b1_d  = b1_q;
    c1_d  = c1_q;
    if (ce_a) begin
      a1_d  = a_i;
      d1_d  = d_i;
      md1_d = mode_i;
    end
    if (ce_b) begin
      b1_d = b_i;
    end
    if (ce_c) begin
      c1_d = c_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1_q  <= '0;
      d1_q  <= '0;
      b1_q  <= '0;
      c1_q  <= '0;
      md1_q <= '0;
    end else begin
      a1_q  <= a1_d;
      d1_q  <= d1_d;
      b1_q  <= b1_d;
      c1_q  <= c1_d;
      md1_q <= md1_d;
    end
  end

  generate
    if (USE_PREADD != 0) begin : g_pre
      // pre-adder stage: one extra register on the A path, B and C kept aligned
      logic signed [MA_W-1:0] a_w, d_w;
      logic signed [MA_W-1:0] sum_q, sum_d;
      logic signed [B_W-1:0]  b2_q, b2_d;
      logic [P_W-1:0]         c2_q, c2_d;
      mode_t                  md2_q, md2_d;

      assign a_w = MA_W'(a1_q);
      assign d_w = MA_W'(d1_q);

      always_comb begin
        sum_d = sum_q;
        md2_d = md2_q;
        b2_d  = b2_q;
        c2_d  = c2_q;
        if (ce_a) begin
          sum_d = md1_q.pre_sub ? (a_w - d_w) : (a_w + d_w);
          md2_d = md1_q;
        end
        if (ce_b) begin
          b2_d = b1_q;
        end
        if (ce_c) begin
          c2_d = c1_q;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sum_q <= '0;
          b2_q  <= '0;
          c2_q  <= '0;
          md2_q <= '0;
        end else begin
          sum_q <= sum_d;
          b2_q  <= b2_d;
          c2_q  <= c2_d;
          md2_q <= md2_d;
        end
      end

      assign mul_a_o = sum_q;
      assign mul_b_o = b2_q;
      assign c_o     = c2_q;
      assign mode_o  = md2_q;
    end else begin : g_byp
      assign mul_a_o = MA_W'(a1_q);
      assign mul_b_o = b1_q;
      assign c_o     = c1_q;
      assign mode_o  = md1_q;
    end
  endgenerate

endmodule

// File: rtl/premac_mult.sv
module premac_mult
  import premac_pkg::*;
#(
  parameter int MA_W = 26,
  parameter int B_W  = 18,
  parameter int P_W  = 48,
  localparam int PR_W = MA_W + B_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_m,
  input  logic signed [MA_W-1:0] mul_a_i,
  input  logic signed [B_W-1:0]  mul_b_i,
  input  logic [P_W-1:0]         c_i,
  input  mode_t                  mode_i,
  output logic [P_W-1:0]         m_o,
  output logic [P_W-1:0]         c_o,
  output mode_t                  mode_o
);

  logic signed [PR_W-1:0] prod;
  logic [P_W-1:0]         m_q, m_d;
  logic [P_W-1:0]         c_q, c_d;
  mode_t                  md_q, md_d;

  assign prod = mul_a_i * mul_b_i;

  always_comb begin
    m_d  = m_q;
    c_d  = c_q;
    md_d = md_q;
    if (ce_m) begin
      m_d  = P_W'(prod);
      c_d  = c_i;
      md_d = mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q  <= '0;
      c_q  <= '0;
      md_q <= '0;
    end else begin
      m_q  <= m_d;
      c_q  <= c_d;
      md_q <= md_d;
    end
  end

  assign m_o    = m_q;
  assign c_o    = c_q;
  assign mode_o = md_q;

endmodule

// File: rtl/premac_post.sv
module premac_post
  import premac_pkg::*;
#(
  parameter int P_W = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce_p,
  input  logic [P_W-1:0] m_i,
  input  logic [P_W-1:0] c_i,
  input  logic [P_W-1:0] casc_i,
  input  mode_t          mode_i,
  output logic [P_W-1:0] p_o
);

  logic [P_W-1:0] p_q, p_d;
  logic [P_W-1:0] z_sel;
  logic [P_W-1:0] alu_res;

  always_comb begin
    unique case (mode_i.zsel)
      ZS_ZERO: z_sel = '0;
      ZS_CASC: z_sel = casc_i;
      ZS_PREG: z_sel = p_q;
      default: z_sel = c_i;
    endcase
  end

  // the inverted form -(Z+M+1) equals the bitwise complement of Z+M
  always_comb begin
    unique case (mode_i.op)
      ALU_ZPM: alu_res = z_sel + m_i;
      ALU_MMZ: alu_res = m_i - z_sel;
      ALU_INV: alu_res = ~(z_sel + m_i);
      default: alu_res = z_sel - m_i;
    endcase
  end

  always_comb begin
    p_d = p_q;
    if (ce_p) begin
      p_d = alu_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
    end else begin
      p_q <= p_d;
    end
  end

  assign p_o = p_q;

endmodule

// File: rtl/premac_slice.sv
module premac_slice
  import premac_pkg::*;
#(
  parameter int A_W        = 25,
  parameter int B_W        = 18,
  parameter int P_W        = 48,
  parameter int USE_PREADD = 1,
  parameter int DROP_LSB   = 0,
  localparam int MA_W      = A_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_a,
  input  logic                    ce_b,
  input  logic                    ce_c,
  input  logic                    ce_m,
  input  logic                    ce_p,
  input  logic [4:0]              mode_i,
  input  logic signed [A_W-1:0]   a_i,
  input  logic signed [A_W-1:0]   d_i,
  input  logic signed [B_W-1:0]   b_i,
  input  logic [P_W-1:0]          c_i,
  input  logic [P_W-1:0]          casc_i,
  output logic [P_W-1-DROP_LSB:0] p_o,
  output logic [P_W-1:0]          casc_o
);

  logic                   rst_n_s;
  mode_t                  mode_w;
  logic signed [MA_W-1:0] mul_a;
  logic signed [B_W-1:0]  mul_b;
  logic [P_W-1:0]         c_f;
  mode_t                  md_f;
  logic [P_W-1:0]         m_q;
  logic [P_W-1:0]         c_q;
  mode_t                  md_q;
  logic [P_W-1:0]         p_q;

  assign mode_w = mode_t'(mode_i);

  premac_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  premac_front #(
    .A_W(A_W), .B_W(B_W), .P_W(P_W), .USE_PREADD(USE_PREADD)
  ) u_front (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ce_a    (ce_a),
    .ce_b    (ce_b),
    .ce_c    (ce_c),
    .a_i     (a_i),
    .d_i     (d_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .mode_i  (mode_w),
    .mul_a_o (mul_a),
    .mul_b_o (mul_b),
    .c_o     (c_f),
    .mode_o  (md_f)
  );

  premac_mult #(
    .MA_W(MA_W), .B_W(B_W), .P_W(P_W)
  ) u_mult (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ce_m    (ce_m),
    .mul_a_i (mul_a),
    .mul_b_i (mul_b),
    .c_i     (c_f),
    .mode_i  (md_f),
    .m_o     (m_q),
    .c_o     (c_q),
    .mode_o  (md_q)
  );

  premac_post #(.P_W(P_W)) u_post (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ce_p   (ce_p),
    .m_i    (m_q),
    .c_i    (c_q),
    .casc_i (casc_i),
    .mode_i (md_q),
    .p_o    (p_q)
  );

  assign p_o    = p_q[P_W-1:DROP_LSB];
  assign casc_o = p_q;

endmodule

// File: rtl/premac_slice_chk.sv
module premac_slice_chk #(
  parameter int P_W = 48
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ce_m,
  input logic           ce_p,
  input logic [P_W-1:0] casc_i,
  input logic [P_W-1:0] casc_o,
  input logic [P_W-1:0] m_q,
  input logic [4:0]     md_q
);

  AST_P_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_p |=> $stable(casc_o)); // R14

  AST_M_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_m |=> $stable(m_q)); // R13

  AST_ACC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_p && md_q[3:0] == 4'b1000) |=> casc_o == $past(casc_o + m_q)); // R6

  AST_INV_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_p && md_q[3:0] == 4'b1010) |=> casc_o == P_W'(0) - $past(casc_o + m_q + P_W'(1))); // R5

  AST_CASC_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_p && md_q[3:0] == 4'b0100) |=> casc_o == $past(casc_i + m_q)); // R4

endmodule

bind premac_slice premac_slice_chk #(.P_W(P_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ce_m   (ce_m),
  .ce_p   (ce_p),
  .casc_i (casc_i),
  .casc_o (casc_o),
  .m_q    (m_q),
  .md_q   (md_q)
);

// File: tb/tb_premac_slice.sv
`timescale 1ns/1ps
module tb_premac_slice;

  logic clk, rst_n;
  logic ce_a, ce_b, ce_c, ce_m, ce_p;
  logic [4:0] md;
  logic signed [24:0] a, d;
  logic signed [17:0] b;
  logic [47:0] c, cs;
  logic [47:0] p0, co0;
  logic [43:0] p1;
  logic [47:0] co1;

  logic [47:0] pm0, pm1;
  int nchk, nfail;

  localparam logic [4:0] IDLE = 5'b01000;

  premac_slice dut (
    .clk(clk), .rst_n(rst_n), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c),
    .ce_m(ce_m), .ce_p(ce_p), .mode_i(md), .a_i(a), .d_i(d), .b_i(b),
    .c_i(c), .casc_i(cs), .p_o(p0), .casc_o(co0)
  );

  premac_slice #(.USE_PREADD(0), .DROP_LSB(4)) dut_b (
    .clk(clk), .rst_n(rst_n), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c),
    .ce_m(ce_m), .ce_p(ce_p), .mode_i(md), .a_i(a), .d_i(d), .b_i(b),
    .c_i(c), .casc_i(cs), .p_o(p1), .casc_o(co1)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [47:0] f_prod(input logic signed [24:0] fa, input logic signed [24:0] fd,
                                         input logic signed [17:0] fb, input logic [4:0] fm, input bit pre);
    logic signed [47:0] ae, de, be, s;
    ae = fa; de = fd; be = fb;
    if (pre) s = fm[4] ? (ae - de) : (ae + de);
    else     s = ae;
    return s * be;
  endfunction

  function automatic logic [47:0] f_alu(input logic [4:0] fm, input logic [47:0] m,
                                        input logic [47:0] fc, input logic [47:0] fcs, input logic [47:0] pold);
    logic [47:0] z;
    case (fm[3:2])
      2'd0: z = 48'd0;
      2'd1: z = fcs;
      2'd2: z = pold;
      default: z = fc;
    endcase
    case (fm[1:0])
      2'd0: return z + m;
      2'd1: return m - z;
      2'd2: return 48'd0 - (z + m + 48'd1);
      default: return z - m;
    endcase
  endfunction

  task automatic chk(input logic [47:0] act, input logic [47:0] exp, input string req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic signed [24:0] ta, input logic signed [24:0] td,
                       input logic signed [17:0] tb, input logic [47:0] tc, input logic [4:0] tm);
    a = ta; d = td; b = tb; c = tc; md = tm;
  endtask

  task automatic idle();
    drive(25'sd0, 25'sd0, 18'sd0, 48'd0, IDLE);
  endtask

  // one vector, then idle until both pipelines have settled; check both slices
  task automatic run_one(input logic signed [24:0] ta, input logic signed [24:0] td,
                         input logic signed [17:0] tb, input logic [47:0] tc,
                         input logic [4:0] tm, input string req);
    @(negedge clk); drive(ta, td, tb, tc, tm);
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    pm0 = f_alu(tm, f_prod(ta, td, tb, tm, 1'b1), tc, cs, pm0);
    pm1 = f_alu(tm, f_prod(ta, td, tb, tm, 1'b0), tc, cs, pm1);
    chk(p0, pm0, req);
    chk(co0, pm0, {req, " R8 cascade out"});
    chk({4'd0, p1}, {4'd0, pm1[47:4]}, {req, " R9 bypass slice"});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ce_a = 1'b1; ce_b = 1'b1; ce_c = 1'b1; ce_m = 1'b1; ce_p = 1'b1;
    cs = 48'd0; idle();
    repeat (3) @(negedge clk);
    chk(p0, 48'd0, "R1 reset p");
    chk(co1, 48'd0, "R1 reset casc");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pm0 = 48'd0; pm1 = 48'd0;
    chk(co0, 48'd0, "R1 after release");
  endtask

  task automatic t_latency();
    logic [47:0] e0, e1;
    e0 = f_alu(5'b01100, f_prod(25'sd3, 25'sd4, 18'sd5, 5'b01100, 1'b1), 48'd1000, cs, pm0);
    e1 = f_alu(5'b01100, f_prod(25'sd3, 25'sd4, 18'sd5, 5'b01100, 1'b0), 48'd1000, cs, pm1);
    @(negedge clk); drive(25'sd3, 25'sd4, 18'sd5, 48'd1000, 5'b01100);
    @(negedge clk); idle();
    @(negedge clk);
    chk(co0, pm0, "R2 pre slice not yet at 2 edges");
    @(negedge clk);
    chk(co0, pm0, "R2 pre slice not yet at 3 edges");
    chk(co1, e1, "R2 bypass slice at 3 edges");
    @(negedge clk);
    chk(co0, e0, "R2 pre slice at 4 edges");
    pm0 = e0; pm1 = e1;
  endtask

  task automatic t_alu();
    for (int op = 0; op < 4; op++)
      run_one(-25'sd1200, 25'sd300, 18'sd77, 48'h0000_0123_4567, {3'b011, 2'(op)}, "R5 alu form");
  endtask

  task automatic t_zsel();
    cs = 48'h00AB_CDEF_0123;
    run_one(25'sd911, -25'sd11, -18'sd1500, 48'hFFFF, 5'b00000, "R4 zero source");
    run_one(25'sd911, -25'sd11, -18'sd1500, 48'hFFFF, 5'b00100, "R4 cascade source");
    run_one(25'sd40, 25'sd2, 18'sd3, 48'hFFFF, 5'b00111, "R4 cascade source minus");
    run_one(25'sd40, 25'sd2, 18'sd3, 48'hFFFF, 5'b01000, "R4 P source");
    run_one(25'sd40, 25'sd2, 18'sd3, 48'hFFFF, 5'b01001, "R4 P source M-Z");
  endtask

  task automatic t_preadd();
    run_one(-25'sd16777216, 25'sd16777215, -18'sd131072, 48'd0, 5'b10000, "R3 pre subtract extremes");
    run_one(25'sd16777215, 25'sd16777215, 18'sd131071, 48'd0, 5'b00000, "R3 pre add extremes");
    run_one(25'sd100, 25'sd30, -18'sd7, 48'd5, 5'b11100, "R3 pre subtract with C");
  endtask

  task automatic t_wrap();
    run_one(25'sd1, 25'sd0, 18'sd1, 48'h7FFF_FFFF_FFFF, 5'b01100, "R7 wrap positive");
    run_one(25'sd1, 25'sd0, 18'sd1, 48'h0, 5'b01110, "R7 inverted of small");
  endtask

  task automatic t_accum();
    logic [47:0] mid;
    @(negedge clk); drive(25'sd100, -25'sd20, -18'sd300, 48'd5000, 5'b01100);
    @(negedge clk); drive(-25'sd7, 25'sd9, 18'sd11, 48'd0, 5'b01000);
    @(negedge clk); drive(25'sd12345, 25'sd678, -18'sd1, 48'd0, 5'b11000);
    @(negedge clk); idle();
    pm0 = f_alu(5'b01100, f_prod(25'sd100, -25'sd20, -18'sd300, 5'b01100, 1'b1), 48'd5000, cs, pm0);
    pm1 = f_alu(5'b01100, f_prod(25'sd100, -25'sd20, -18'sd300, 5'b01100, 1'b0), 48'd5000, cs, pm1);
    mid = pm0;
    pm0 = pm0 + f_prod(-25'sd7, 25'sd9, 18'sd11, 5'b01000, 1'b1);
    pm1 = pm1 + f_prod(-25'sd7, 25'sd9, 18'sd11, 5'b01000, 1'b0);
    pm0 = pm0 + f_prod(25'sd12345, 25'sd678, -18'sd1, 5'b11000, 1'b1);
    pm1 = pm1 + f_prod(25'sd12345, 25'sd678, -18'sd1, 5'b11000, 1'b0);
    @(negedge clk);
    chk(co0, mid, "R6 restart term");
    repeat (3) @(negedge clk);
    chk(co0, pm0, "R6 accumulated sum");
    chk(co1, pm1, "R6 accumulated sum bypass");
  endtask

  task automatic t_ce_a();
    @(negedge clk); drive(25'sd7, 25'sd3, 18'sd9, 48'd500, 5'b01100); ce_a = 1'b0;
    @(negedge clk); ce_a = 1'b1; idle();
    repeat (4) @(negedge clk);
    chk(co0, pm0, "R10 A stage held, vector dropped");
    chk(co1, pm1, "R10 A stage held bypass");
  endtask

  task automatic t_ce_b();
    @(negedge clk); drive(25'sd7, 25'sd2, 18'sd9, 48'd500, 5'b01100); ce_b = 1'b0;
    @(negedge clk); ce_b = 1'b1; idle();
    repeat (4) @(negedge clk);
    pm0 = 48'd500; pm1 = 48'd500;
    chk(co0, pm0, "R11 B stage held");
    chk(co1, pm1, "R11 B stage held bypass");
  endtask

  task automatic t_ce_c();
    @(negedge clk); drive(25'sd7, 25'sd2, 18'sd9, 48'd500, 5'b01100); ce_c = 1'b0;
    @(negedge clk); ce_c = 1'b1; idle();
    repeat (4) @(negedge clk);
    pm0 = 48'd81; pm1 = 48'd63;
    chk(co0, pm0, "R12 C stage held");
    chk(co1, pm1, "R12 C stage held bypass");
  endtask

  task automatic t_ce_m();
    logic [47:0] m;
    m = f_prod(25'sd5, 25'sd1, 18'sd3, 5'b01000, 1'b1);
    @(negedge clk); drive(25'sd5, 25'sd1, 18'sd3, 48'd0, 5'b01000);
    @(negedge clk); idle();
    @(negedge clk);
    @(negedge clk); ce_m = 1'b0;
    @(negedge clk); ce_m = 1'b1;
    chk(co0, pm0 + m, "R13 first application");
    @(negedge clk);
    pm0 = pm0 + m + m;
    pm1 = pm1 + f_prod(25'sd5, 25'sd1, 18'sd3, 5'b01000, 1'b0);
    chk(co0, pm0, "R13 product applied twice");
    chk(co1, pm1, "R13 bypass slice unaffected");
  endtask

  task automatic t_ce_p();
    @(negedge clk); drive(25'sd2, 25'sd0, 18'sd2, 48'd777, 5'b01100);
    @(negedge clk); idle();
    @(negedge clk);
    @(negedge clk); ce_p = 1'b0;
    @(negedge clk);
    pm1 = 48'd781;
    chk(co0, pm0, "R14 P held during stall");
    chk(co1, pm1, "R14 bypass updated before stall");
    ce_p = 1'b1;
    repeat (2) @(negedge clk);
    chk(co0, pm0, "R14 stalled term lost");
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(co0, 48'd0, "R1 asynchronous clear");
    chk({4'd0, p1}, 48'd0, "R1 asynchronous clear bypass");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pm0 = 48'd0; pm1 = 48'd0;
    run_one(25'sd6, 25'sd6, 18'sd6, 48'd1, 5'b01100, "R1 run after reset");
  endtask

  initial begin
    nchk = 0; nfail = 0;
    t_reset();
    t_latency();
    t_alu();
    t_zsel();
    t_preadd();
    t_wrap();
    t_accum();
    t_ce_a();
    t_ce_b();
    t_ce_c();
    t_ce_m();
    t_ce_p();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule